// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block is the power-state sequencer that sits beside a processor core. It tracks six states: run, halted power-down, stop-granted, clock-stopped, snoop wake and cache flush. Its inputs are a stop request from the system, an indication that the core executed a halt instruction, two alternative bus-ready handshakes, a snoop strobe with a hit-on-modified-line flag, a flush request with its completion strobe, three interrupt lines, hard and soft reset events, and a flag that says whether the input clock is running. It asks the bus unit for one-cycle special bus cycles (stop-grant or halt), shows the current state one-hot, and passes interrupt lines on to the core only in states where they may be recognised.

Entry into the stop-granted state is a two-step handshake. First a stop-grant cycle is requested. Then one of the two ready inputs must return. When the stop request is released, a programmable delay of 10 to 20 clocks runs before the block goes back to the state it came from. Snoop wake and cache flush each keep a return register, so they go back to their origin. They only re-issue a special cycle where the requirements below call for it.

Top module: `pm_stopclk_ctrl`

## Requirements
- R1: In run or halted state, a high `stop_req_i` produces a one-cycle `bus_req_o` with `bus_kind_o`=1 (stop-grant). The state then stays put until `ready_a_i` or `ready_b_i` is sampled high. `state_o` shows stop-granted from the following edge.
- R2: Once `stop_req_i` is sampled low in stop-granted state at edge E0, the block leaves that state at edge E0+D. D is `resume_dly_i` clamped to the range 10..20 and captured at E0.
- R3: A stop-grant cycle is requested only on entry from run or halted. The clock-stopped to stop-granted return raises no `bus_req_o`, and a return to run from stop-granted raises none either.
- R4: In stop-granted state with no resume pending, a low `clk_present_i` moves the block to clock-stopped at the next edge. A high `clk_present_i` moves it back to stop-granted at the next edge.
- R5: A high `halt_i` in run state moves the block to halted and raises `bus_req_o` with `bus_kind_o`=0 (halt). Halted state is left for run only on a recognised interrupt or on a reset event. Other inputs such as `hit_mod_i` or `flush_done_i` alone do not leave it.
- R6: Halted state left for stop-granted returns to halted after the resume delay, and it raises a fresh halt cycle (`bus_kind_o`=0) on that same edge.
- R7: `snoop_strobe_i` in stop-granted (no resume pending) or halted state enters snoop wake for one clock. If `hit_mod_i` is high in that clock, `dirty_hit_o` is held high and the block stays in snoop wake until `wb_done_i`. It then returns to its origin state with no `bus_req_o`.
- R8: `irq_o` (bit 0 maskable, bit 1 non-maskable, bit 2 management) follows the raw interrupt lines in run and halted states. It is zero in stop-granted until the stop request is sampled low, and zero in clock-stopped and snoop wake. It follows the raw lines again from the first clock after the release.
- R9: `hard_reset_i` or `soft_reset_i` moves the block from any clocked state, stop-granted included, to run at the next edge.
- R10: `flush_req_i` is accepted only in run or halted state and is ignored in stop-granted state. On `flush_done_i` the block returns to its origin. It raises a halt cycle if that origin is halted, and no cycle if the origin is run.
- R11: `state_o` is one-hot: bit 0 run, bit 1 halted, bit 2 stop-granted, bit 3 clock-stopped, bit 4 snoop wake, bit 5 flush. After reset it shows run, with `bus_req_o` and `dirty_hit_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_i | input | 1 | System stop-clock request |
| halt_i | input | 1 | Core executed a halt instruction |
| ready_a_i | input | 1 | Bus ready handshake, first form |
| ready_b_i | input | 1 | Bus ready handshake, second form |
| snoop_strobe_i | input | 1 | Snoop address strobe |
| hit_mod_i | input | 1 | Snoop hit a modified line |
| wb_done_i | input | 1 | Snoop write-back finished |
| flush_req_i | input | 1 | Cache flush request |
| flush_done_i | input | 1 | Cache flush finished |
| maskable_irq_i | input | 1 | Maskable interrupt line |
| nonmask_irq_i | input | 1 | Non-maskable interrupt line |
| mgmt_irq_i | input | 1 | System management interrupt line |
| hard_reset_i | input | 1 | Hard reset event |
| soft_reset_i | input | 1 | Soft reset event |
| clk_present_i | input | 1 | Input clock running |
| resume_dly_i | input | 5 | Resume delay in clocks, clamped to 10..20 |
| bus_req_o | output | 1 | One-cycle special bus cycle request |
| bus_kind_o | output | 1 | Cycle kind: 1 stop-grant, 0 halt |
| dirty_hit_o | output | 1 | Modified line hit, write-back pending |
| irq_o | output | 3 | Qualified interrupts {management, non-maskable, maskable} |
| state_o | output | 6 | One-hot current state |

## Verification
The bench uses the default parameters: a 5-bit delay input with clamp bounds 10 and 20. With these it can drive delay values below, inside and above the legal window (3, 10, 15, 31) and check the exact exit edge of each. The short legal window keeps every resume path within a few dozen cycles. So each scenario can cover both origins (run and halted), both ready forms, the clock-stopped detour and snoops with and without a modified hit.

// File: rtl/pm_stopclk_pkg.sv
package pm_stopclk_pkg;

  localparam int unsigned N_STATE = 6;
  localparam int unsigned N_IRQ   = 3;

  localparam int unsigned IX_RUN   = 0;
  localparam int unsigned IX_HALT  = 1;
  localparam int unsigned IX_SGNT  = 2;
  localparam int unsigned IX_CSTOP = 3;
  localparam int unsigned IX_SNOOP = 4;
  localparam int unsigned IX_FLUSH = 5;

  typedef enum logic [N_STATE-1:0] {
    PM_RUN   = 6'b000001,
    PM_HALT  = 6'b000010,
    PM_SGNT  = 6'b000100,
    PM_CSTOP = 6'b001000,
    PM_SNOOP = 6'b010000,
    PM_FLUSH = 6'b100000
  } pm_state_e;

  typedef enum logic {
    CYC_HALT    = 1'b0,
    CYC_STOPGNT = 1'b1
  } pm_cyc_e;

endpackage

// File: rtl/pm_resume_timer.sv
module pm_resume_timer #(
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned MIN_DLY = 10,
  parameter int unsigned MAX_DLY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             cancel_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             active_o,
  output logic             expire_o
);

  localparam int unsigned CNT_W = $clog2(MAX_DLY + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] dly_clamped;

  always_comb begin
    if (int'(dly_i) < int'(MIN_DLY)) begin
      dly_clamped = CNT_W'(MIN_DLY);
    end else if (int'(dly_i) > int'(MAX_DLY)) begin
      dly_clamped = CNT_W'(MAX_DLY);
    end else begin
      dly_clamped = CNT_W'(dly_i);
    end
  end

  assign expire_o = active_q && (cnt_q == dly_q);
  assign active_o = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dly_q    <= CNT_W'(MIN_DLY);
    end else if (cancel_i) begin
      active_q <= 1'b0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
      dly_q    <= dly_clamped;
    end else if (active_q) begin
      if (expire_o) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= dly_q));

  a_r2_dly_window: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> ((dly_q >= CNT_W'(MIN_DLY)) && (dly_q <= CNT_W'(MAX_DLY))));

endmodule

// File: rtl/pm_snoop_track.sv
module pm_snoop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_snoop_i,
  input  logic hit_mod_i,
  input  logic wb_done_i,
  input  logic abort_i,
  output logic dirty_o,
  output logic done_o
);

  logic pend_q;

  assign dirty_o = pend_q;
  assign done_o  = in_snoop_i && ((!pend_q && !hit_mod_i) || (pend_q && wb_done_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (abort_i) begin
      pend_q <= 1'b0;
    end else if (in_snoop_i && !pend_q && hit_mod_i) begin
      pend_q <= 1'b1;
    end else if (pend_q && wb_done_i) begin
      pend_q <= 1'b0;
    end
  end

  a_r7_dirty_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> in_snoop_i);

endmodule

// File: rtl/pm_irq_gate.sv
module pm_irq_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] raw_i,
  input  logic         recog_i,
  output logic [N-1:0] irq_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    assign irq_o[g] = raw_i[g] & recog_i;
  end

endmodule

// File: rtl/pm_stopclk_ctrl.sv
module pm_stopclk_ctrl
  import pm_stopclk_pkg::*;
#(
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned MIN_DLY = 10,
  parameter int unsigned MAX_DLY = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req_i,
  input  logic               halt_i,
  input  logic               ready_a_i,
  input  logic               ready_b_i,
  input  logic               snoop_strobe_i,
  input  logic               hit_mod_i,
  input  logic               wb_done_i,
  input  logic               flush_req_i,
  input  logic               flush_done_i,
  input  logic               maskable_irq_i,
  input  logic               nonmask_irq_i,
  input  logic               mgmt_irq_i,
  input  logic               hard_reset_i,
  input  logic               soft_reset_i,
  input  logic               clk_present_i,
  input  logic [DLY_W-1:0]   resume_dly_i,
  output logic               bus_req_o,
  output logic               bus_kind_o,
  output logic               dirty_hit_o,
  output logic [N_IRQ-1:0]   irq_o,
  output logic [N_STATE-1:0] state_o
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pm_state_e state_q, state_d;
  pm_state_e ret_aux_q, ret_aux_d;
  logic      from_halt_q, from_halt_d;
  logic      sg_pend_q, sg_pend_d;
  logic      req_q, req_d;
  pm_cyc_e   kind_q, kind_d;

  logic tmr_arm, tmr_cancel, tmr_active, tmr_expire;
  logic snp_done, force_run, recog, irq_any;
  logic ready_any;

  assign force_run = hard_reset_i | soft_reset_i;
  assign ready_any = ready_a_i | ready_b_i;
  assign recog     = state_q[IX_RUN] | state_q[IX_HALT] | (state_q[IX_SGNT] & tmr_active);
  assign irq_any   = |irq_o;

  pm_irq_gate #(.N(N_IRQ)) u_gate (
    .raw_i   ({mgmt_irq_i, nonmask_irq_i, maskable_irq_i}),
    .recog_i (recog),
    .irq_o   (irq_o)
  );

  pm_resume_timer #(
    .DLY_W   (DLY_W),
    .MIN_DLY (MIN_DLY),
    .MAX_DLY (MAX_DLY)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm_i    (tmr_arm),
    .cancel_i (tmr_cancel),
    .dly_i    (resume_dly_i),
    .active_o (tmr_active),
    .expire_o (tmr_expire)
  );

  pm_snoop_track u_snoop (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_snoop_i (state_q[IX_SNOOP]),
    .hit_mod_i  (hit_mod_i),
    .wb_done_i  (wb_done_i),
    .abort_i    (force_run),
    .dirty_o    (dirty_hit_o),
    .done_o     (snp_done)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    ret_aux_d   = ret_aux_q;
    from_halt_d = from_halt_q;
    sg_pend_d   = sg_pend_q;
    req_d       = 1'b0;
    kind_d      = kind_q;
    tmr_arm     = 1'b0;
    tmr_cancel  = 1'b0;

    if (force_run) begin
      state_d    = PM_RUN;
      sg_pend_d  = 1'b0;
      tmr_cancel = 1'b1;
    end else begin
      unique case (state_q)
        PM_RUN: begin
          if (sg_pend_q) begin
            if (ready_any) begin
              state_d     = PM_SGNT;
              from_halt_d = 1'b0;
              sg_pend_d   = 1'b0;
            end
          end else if (stop_req_i) begin
            sg_pend_d = 1'b1;
            req_d     = 1'b1;
            kind_d    = CYC_STOPGNT;
          end else if (flush_req_i) begin
            state_d   = PM_FLUSH;
            ret_aux_d = PM_RUN;
          end else if (halt_i) begin
            state_d = PM_HALT;
            req_d   = 1'b1;
            kind_d  = CYC_HALT;
          end
        end

        PM_HALT: begin
          if (sg_pend_q) begin
            if (ready_any) begin
              state_d     = PM_SGNT;
              from_halt_d = 1'b1;
              sg_pend_d   = 1'b0;
            end
          end else if (irq_any) begin
            state_d = PM_RUN;
          end else if (stop_req_i) begin
            sg_pend_d = 1'b1;
            req_d     = 1'b1;
            kind_d    = CYC_STOPGNT;
          end else if (snoop_strobe_i) begin
            state_d   = PM_SNOOP;
            ret_aux_d = PM_HALT;
          end else if (flush_req_i) begin
            state_d   = PM_FLUSH;
            ret_aux_d = PM_HALT;
          end
        end

        PM_SGNT: begin
          if (tmr_active) begin
            if (stop_req_i) begin
              tmr_cancel = 1'b1;
            end else if (tmr_expire) begin
              if (from_halt_q) begin
                state_d = PM_HALT;
                req_d   = 1'b1;
                kind_d  = CYC_HALT;
              end else begin
                state_d = PM_RUN;
              end
            end
          end else if (!stop_req_i) begin
            tmr_arm = 1'b1;
          end else if (!clk_present_i) begin
            state_d = PM_CSTOP;
          end else if (snoop_strobe_i) begin
            state_d   = PM_SNOOP;
            ret_aux_d = PM_SGNT;
          end
        end

        PM_CSTOP: begin
          if (clk_present_i) begin
            state_d = PM_SGNT;
          end
        end

        PM_SNOOP: begin
          if (snp_done) begin
            state_d = ret_aux_q;
          end
        end

        PM_FLUSH: begin
          if (flush_done_i) begin
            state_d = ret_aux_q;
            if (ret_aux_q == PM_HALT) begin
              req_d  = 1'b1;
              kind_d = CYC_HALT;
            end
          end
        end

        default: begin
          state_d = PM_RUN;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= PM_RUN;
      ret_aux_q   <= PM_RUN;
      from_halt_q <= 1'b0;
      sg_pend_q   <= 1'b0;
      req_q       <= 1'b0;
      kind_q      <= CYC_HALT;
    end else begin
      state_q     <= state_d;
      ret_aux_q   <= ret_aux_d;
      from_halt_q <= from_halt_d;
      sg_pend_q   <= sg_pend_d;
      req_q       <= req_d;
      kind_q      <= kind_d;
    end
  end

  assign bus_req_o  = req_q;
  assign bus_kind_o = kind_q;
  assign state_o    = state_q;

  a_r11_one_hot: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(state_q) == 1);

  a_r1_grant_after_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(state_q[IX_SGNT]) && $past(state_q[IX_RUN] | state_q[IX_HALT]))
      |-> $past(ready_a_i | ready_b_i));

  a_r3_quiet_clock_return: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(state_q[IX_CSTOP]) && state_q[IX_SGNT]) |-> !bus_req_o);

  a_r7_quiet_snoop_return: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(state_q[IX_SNOOP]) |-> !bus_req_o);

  a_r8_masked_states: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q[IX_CSTOP] | state_q[IX_SNOOP]) |-> (irq_o == '0));

  a_r9_reset_to_run: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hard_reset_i | soft_reset_i) |=> state_q[IX_RUN]);

  a_r10_flush_source: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(state_q[IX_FLUSH]) |-> $past(state_q[IX_RUN] | state_q[IX_HALT]));

endmodule

// File: tb/pm_stopclk_ctrl_bench.sv
`timescale 1ns/1ps
module pm_stopclk_ctrl_bench;

  localparam logic [5:0] S_RUN   = 6'b000001;
  localparam logic [5:0] S_HALT  = 6'b000010;
  localparam logic [5:0] S_SGNT  = 6'b000100;
  localparam logic [5:0] S_CSTOP = 6'b001000;
  localparam logic [5:0] S_SNOOP = 6'b010000;
  localparam logic [5:0] S_FLUSH = 6'b100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req, halt, rdy_a, rdy_b, snoop, hit_mod, wb_done;
  logic       flush_req, flush_done, irq_m, irq_n, irq_s, hard_rst, soft_rst, clk_ok;
  logic [4:0] dly;
  logic       bus_req, bus_kind, dirty;
  logic [2:0] irq;
  logic [5:0] state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pm_stopclk_ctrl u_pm_stopclk_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_req_i     (stop_req),
    .halt_i         (halt),
    .ready_a_i      (rdy_a),
    .ready_b_i      (rdy_b),
    .snoop_strobe_i (snoop),
    .hit_mod_i      (hit_mod),
    .wb_done_i      (wb_done),
    .flush_req_i    (flush_req),
    .flush_done_i   (flush_done),
    .maskable_irq_i (irq_m),
    .nonmask_irq_i  (irq_n),
    .mgmt_irq_i     (irq_s),
    .hard_reset_i   (hard_rst),
    .soft_reset_i   (soft_rst),
    .clk_present_i  (clk_ok),
    .resume_dly_i   (dly),
    .bus_req_o      (bus_req),
    .bus_kind_o     (bus_kind),
    .dirty_hit_o    (dirty),
    .irq_o          (irq),
    .state_o        (state)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1: request, hold without ready, then ready moves to stop-granted
  task automatic enter_grant(input bit use_b);
    stop_req = 1'b1;
    tick();
    chk("R1 stop-grant request", bus_req, 1);
    chk("R1 stop-grant kind", bus_kind, 1);
    tick();
    chk("R1 waits for ready", state, state == S_SGNT ? 0 : state);
    chk("R1 single pulse", bus_req, 0);
    if (use_b) rdy_b = 1'b1; else rdy_a = 1'b1;
    tick();
    rdy_a = 1'b0;
    rdy_b = 1'b0;
    chk("R1 granted after ready", state, S_SGNT);
  endtask

  // R2/R8: release stop request, exit exactly d clocks after the sampling edge
  task automatic release_grant(input int d, input logic [5:0] exp_st, input bit exp_req);
    stop_req = 1'b0;
    tick();
    chk("R8 recognised after release", irq, {irq_s, irq_n, irq_m});
    for (int i = 1; i < d; i++) tick();
    chk("R2 still granted before delay", state, S_SGNT);
    tick();
    chk("R2 exit at delay", state, exp_st);
    chk("R3 R6 return request", bus_req, exp_req);
    if (exp_req) chk("R6 halt kind on return", bus_kind, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    stop_req = 0; halt = 0; rdy_a = 0; rdy_b = 0; snoop = 0; hit_mod = 0; wb_done = 0;
    flush_req = 0; flush_done = 0; irq_m = 0; irq_n = 0; irq_s = 0;
    hard_rst = 0; soft_rst = 0; clk_ok = 1; dly = 5'd15;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R11 reset state", state, S_RUN);
    chk("R11 reset bus request", bus_req, 0);
    chk("R11 reset dirty flag", dirty, 0);
  endtask

  task automatic t_grant_from_run();
    enter_grant(1'b0);
    irq_m = 1'b1;
    tick();
    chk("R8 masked in stop-granted", irq, 0);
    dly = 5'd15;
    release_grant(15, S_RUN, 1'b0);
    chk("R8 held interrupt serviced", irq, 3'b001);
    irq_m = 1'b0;
  endtask

  task automatic t_clamp();
    enter_grant(1'b1);
    dly = 5'd3;
    release_grant(10, S_RUN, 1'b0);
    enter_grant(1'b0);
    dly = 5'd31;
    release_grant(20, S_RUN, 1'b0);
  endtask

  task automatic t_clock_stop();
    enter_grant(1'b0);
    clk_ok = 1'b0;
    tick();
    chk("R4 clock stopped", state, S_CSTOP);
    irq_s = 1'b1;
    tick();
    chk("R8 masked while clock stopped", irq, 0);
    irq_s = 1'b0;
    clk_ok = 1'b1;
    tick();
    chk("R4 back to granted", state, S_SGNT);
    chk("R3 no request on clock return", bus_req, 0);
    dly = 5'd10;
    release_grant(10, S_RUN, 1'b0);
  endtask

  task automatic t_snoop_grant();
    enter_grant(1'b1);
    snoop = 1'b1;
    tick();
    snoop = 1'b0;
    chk("R7 snoop wake", state, S_SNOOP);
    tick();
    chk("R7 one clock then back", state, S_SGNT);
    chk("R7 no request after snoop", bus_req, 0);
    chk("R7 no dirty on clean snoop", dirty, 0);
    snoop = 1'b1;
    tick();
    snoop = 1'b0;
    hit_mod = 1'b1;
    tick();
    hit_mod = 1'b0;
    chk("R7 dirty hit raised", dirty, 1);
    chk("R7 held in snoop", state, S_SNOOP);
    tick();
    chk("R7 dirty held until done", dirty, 1);
    wb_done = 1'b1;
    tick();
    wb_done = 1'b0;
    chk("R7 back after write-back", state, S_SGNT);
    chk("R7 dirty cleared", dirty, 0);
    chk("R7 quiet return", bus_req, 0);
  endtask

  task automatic t_grant_ignores_and_reset();
    flush_req = 1'b1;
    halt = 1'b1;
    tick();
    flush_req = 1'b0;
    halt = 1'b0;
    tick();
    chk("R10 flush ignored in granted", state, S_SGNT);
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk("R9 soft reset to run", state, S_RUN);
    stop_req = 1'b0;
    tick();
    enter_grant(1'b0);
    hard_rst = 1'b1;
    stop_req = 1'b0;
    tick();
    hard_rst = 1'b0;
    chk("R9 hard reset to run", state, S_RUN);
  endtask

  task automatic t_halt_paths();
    halt = 1'b1;
    tick();
    halt = 1'b0;
    chk("R5 halted", state, S_HALT);
    chk("R5 halt request", bus_req, 1);
    chk("R5 halt kind", bus_kind, 0);
    hit_mod = 1'b1;
    flush_done = 1'b1;
    tick();
    hit_mod = 1'b0;
    flush_done = 1'b0;
    chk("R5 stray inputs keep halt", state, S_HALT);
    flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    chk("R10 flush from halt", state, S_FLUSH);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk("R10 back to halt", state, S_HALT);
    chk("R10 halt cycle reissued", bus_req, 1);
    chk("R10 reissued kind", bus_kind, 0);
    snoop = 1'b1;
    tick();
    snoop = 1'b0;
    chk("R7 snoop from halt", state, S_SNOOP);
    tick();
    chk("R7 back to halt", state, S_HALT);
    chk("R7 no request to halt", bus_req, 0);
    enter_grant(1'b1);
    dly = 5'd12;
    release_grant(12, S_HALT, 1'b1);
    irq_n = 1'b1;
    tick();
    irq_n = 1'b0;
    chk("R5 interrupt leaves halt", state, S_RUN);
    halt = 1'b1;
    tick();
    halt = 1'b0;
    hard_rst = 1'b1;
    tick();
    hard_rst = 1'b0;
    chk("R5 reset leaves halt", state, S_RUN);
  endtask

  task automatic t_flush_run();
    flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    chk("R10 flush from run", state, S_FLUSH);
    tick();
    chk("R10 waits for done", state, S_FLUSH);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk("R10 back to run", state, S_RUN);
    chk("R10 no cycle for run", bus_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_grant_from_run();
    t_clamp();
    t_clock_stop();
    t_snoop_grant();
    t_grant_ignores_and_reset();
    t_halt_paths();
    t_flush_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule